// File: doc/BRIEF.md
# Synchronous Character Hunt Detector

The block watches a serial receive bit stream for a programmed synchronization pattern. A receive operation opens in the hunt phase. On every accepted bit it compares the most recent bits against the programmed sync characters, at whatever bit offset they arrive, so the match does not have to fall on a byte boundary. Three hunt modes are supported:

- a single sync character;
- a pair of sync characters received back to back;
- a bit-oriented flag pattern.

The first match ends the hunt. From then on, every accepted bit bypasses the comparison window and goes straight into character assembly. Each group of eight bits is delivered as one character strobe with its data.

Bits enter on `rx_bit`, qualified by the `rx_valid` strobe. The serial line cannot be stalled, so the input stream has no ready signal and the block accepts every strobed bit. The character output is a valid-only stream, `char_valid` with `char_data`, and it has no back-pressure either: the consumer must take each strobe in the cycle it appears. The control pins (`mode`, `sync_a`, `sync_b`, `hunt_restart`) and the status pin `in_sync` are plain levels.

Top module: `sync_hunt`

## Requirements
- R1: After reset, `in_sync` and `char_valid` are 0 and the block is hunting.
- R2: Bits are taken least significant bit first, so the earliest of the eight compared bits sits in bit 0. In single mode (`mode` = 2'b00), `in_sync` goes to 1 in the clock after the strobe of the bit that makes the last eight accepted bits equal `sync_b`. This holds at any bit offset.
- R3: In dual mode (`mode` = 2'b01), sync requires two conditions at the same bit: the newest eight bits equal `sync_b`, and the eight bits before them equal `sync_a`. A lone `sync_b` preceded by other bits does not give sync.
- R4: In flag mode (`mode` = 2'b10 or 2'b11), the last eight bits are compared with `sync_b`, and `sync_a` has no effect.
- R5: No match is declared until at least 8 bits (single or flag mode) or 16 bits (dual mode) have been accepted since reset or the last restart.
- R6: A cycle with `rx_valid` at 0 neither shifts the hunt window nor advances character assembly, whatever `rx_bit` is.
- R7: Once in sync, `char_valid` pulses for one clock after every eighth accepted bit. Counting starts with the first bit after the matching one. `char_data` holds those eight bits, first received in bit 0, and the pulse appears in the clock after the eighth strobe.
- R8: Asserting `hunt_restart` clears `in_sync` at the next clock, discards any partial character and empties the hunt window. A bit strobed in the same cycle is discarded.
- R9: While in sync and without a restart, `in_sync` stays 1. A byte equal to a sync character is then delivered as an ordinary character.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_bit | input | 1 | Serial receive bit |
| rx_valid | input | 1 | Bit strobe; `rx_bit` is accepted in this cycle |
| mode | input | 2 | Hunt mode: 00 single, 01 dual, 1x flag |
| sync_a | input | 8 | First (older) sync character, dual mode only |
| sync_b | input | 8 | Sync character / flag pattern, all modes |
| hunt_restart | input | 1 | Return to hunt on the next clock |
| in_sync | output | 1 | Synchronization acquired |
| char_valid | output | 1 | One-cycle strobe: an assembled character is ready |
| char_data | output | 8 | Assembled character, first bit in bit 0 |

## Verification
A restart and a bit strobe can land in the same cycle. The case that matters is a strobe carrying the final bit of a sync pattern, which on its own would end the hunt. The bench drives `hunt_restart` together with exactly that completing bit. The restart must win: `in_sync` stays 0 after the clock, and the full pattern must then be sent again before sync appears. The bench also restarts in the middle of a character, and judges that no stale bits leak into the first character after the next sync.

// File: rtl/sync_hunt_pkg.sv
package sync_hunt_pkg;
  typedef enum logic [1:0] {
    HUNT_SINGLE   = 2'b00,
    HUNT_DUAL     = 2'b01,
    HUNT_FLAG     = 2'b10,
    HUNT_FLAG_ALT = 2'b11
  } hunt_mode_e;
endpackage

// File: rtl/sync_hunt_window.sv
// Hunt-phase comparison window: newest byte plus the byte before it.
module sync_hunt_window #(
  parameter int W  = 8,
  parameter int CW = $clog2(2 * W + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clear,
  input  logic          shift_en,
  input  logic          bit_in,
  output logic [W-1:0]  nxt_new,
  output logic [W-1:0]  nxt_old,
  output logic [CW-1:0] nxt_fill
);
  localparam logic [CW-1:0] FILL_MAX = CW'(2 * W);

  logic [W-1:0]  newest_q;
  logic [W-1:0]  older_q;
  logic [CW-1:0] fill_q;

  // LSB-first: new bit enters at the top and walks toward bit 0.
  assign nxt_new  = {bit_in, newest_q[W-1:1]};
  assign nxt_old  = {newest_q[0], older_q[W-1:1]};
  assign nxt_fill = (fill_q == FILL_MAX) ? fill_q : fill_q + CW'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      newest_q <= '0;
      older_q  <= '0;
      fill_q   <= '0;
    end else if (clear) begin
      newest_q <= '0;
      older_q  <= '0;
      fill_q   <= '0;
    end else if (shift_en) begin
      newest_q <= nxt_new;
      older_q  <= nxt_old;
      fill_q   <= nxt_fill;
    end
  end

  // R6
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!shift_en && !clear) |=> ($stable(newest_q) && $stable(older_q)));

  // R5
  fill_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fill_q <= FILL_MAX);
endmodule

// File: rtl/sync_hunt_match.sv
// Pattern comparison for the three hunt modes, gated by window fill.
module sync_hunt_match
  import sync_hunt_pkg::*;
#(
  parameter int W  = 8,
  parameter int CW = $clog2(2 * W + 1)
) (
  input  hunt_mode_e    mode,
  input  logic [W-1:0]  sync_a,
  input  logic [W-1:0]  sync_b,
  input  logic [W-1:0]  cand_new,
  input  logic [W-1:0]  cand_old,
  input  logic [CW-1:0] cand_fill,
  output logic          hit
);
  localparam logic [CW-1:0] NEED_ONE = CW'(W);
  localparam logic [CW-1:0] NEED_TWO = CW'(2 * W);

  logic new_eq, old_eq;

  assign new_eq = (cand_new == sync_b);
  assign old_eq = (cand_old == sync_a);

  always_comb begin
    unique case (mode)
      HUNT_DUAL:                hit = (cand_fill >= NEED_TWO) && new_eq && old_eq;
      HUNT_FLAG, HUNT_FLAG_ALT: hit = (cand_fill >= NEED_ONE) && new_eq;
      default:                  hit = (cand_fill >= NEED_ONE) && new_eq;
    endcase
  end
endmodule

// File: rtl/sync_hunt_assemble.sv
// Post-sync character assembly: one strobe per W accepted bits.
module sync_hunt_assemble #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clear,
  input  logic         bit_en,
  input  logic         bit_in,
  output logic         char_valid,
  output logic [W-1:0] char_data
);
  localparam int          CNTW = (W > 1) ? $clog2(W) : 1;
  localparam logic [CNTW-1:0] LAST = CNTW'(W - 1);

  logic [W-1:0]    shreg_q;
  logic [W-1:0]    shreg_nxt;
  logic [CNTW-1:0] cnt_q;

  assign shreg_nxt = {bit_in, shreg_q[W-1:1]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg_q    <= '0;
      cnt_q      <= '0;
      char_valid <= 1'b0;
      char_data  <= '0;
    end else if (clear) begin
      shreg_q    <= '0;
      cnt_q      <= '0;
      char_valid <= 1'b0;
    end else begin
      char_valid <= 1'b0;
      if (bit_en) begin
        shreg_q <= shreg_nxt;
        if (cnt_q == LAST) begin
          cnt_q      <= '0;
          char_valid <= 1'b1;
          char_data  <= shreg_nxt;
        end else begin
          cnt_q <= cnt_q + CNTW'(1);
        end
      end
    end
  end

  // R7
  pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    char_valid |=> !char_valid);

  // R6
  idle_cnt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!bit_en && !clear) |=> $stable(cnt_q));
endmodule

// File: rtl/sync_hunt.sv
// Synchronous character hunt detector, top level.
module sync_hunt
  import sync_hunt_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         rx_bit,
  input  logic         rx_valid,
  input  logic [1:0]   mode,
  input  logic [W-1:0] sync_a,
  input  logic [W-1:0] sync_b,
  input  logic         hunt_restart,
  output logic         in_sync,
  output logic         char_valid,
  output logic [W-1:0] char_data
);
  localparam int CW = $clog2(2 * W + 1);

  logic          take;
  logic          hit;
  logic [W-1:0]  win_new, win_old;
  logic [CW-1:0] win_fill;

  // Restart has priority: a bit strobed alongside it is dropped.
  assign take = rx_valid && !hunt_restart;

  sync_hunt_window #(.W(W), .CW(CW)) u_window (
    .clk      (clk),
    .rst_n    (rst_n),
    .clear    (hunt_restart),
    .shift_en (take && !in_sync),
    .bit_in   (rx_bit),
    .nxt_new  (win_new),
    .nxt_old  (win_old),
    .nxt_fill (win_fill)
  );

  sync_hunt_match #(.W(W), .CW(CW)) u_match (
    .mode      (hunt_mode_e'(mode)),
    .sync_a    (sync_a),
    .sync_b    (sync_b),
    .cand_new  (win_new),
    .cand_old  (win_old),
    .cand_fill (win_fill),
    .hit       (hit)
  );

  sync_hunt_assemble #(.W(W)) u_assemble (
    .clk        (clk),
    .rst_n      (rst_n),
    .clear      (hunt_restart || !in_sync),
    .bit_en     (take && in_sync),
    .bit_in     (rx_bit),
    .char_valid (char_valid),
    .char_data  (char_data)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                     in_sync <= 1'b0;
    else if (hunt_restart)          in_sync <= 1'b0;
    else if (take && !in_sync && hit) in_sync <= 1'b1;
  end

  // R8
  restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hunt_restart |=> !in_sync);

  // R2
  rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(in_sync) |-> $past(rx_valid && !hunt_restart));

  // R7
  char_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    char_valid |-> in_sync);

  // R9
  stay_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_sync && !hunt_restart) |=> in_sync);
endmodule

// File: tb/sync_hunt_bench.sv
`timescale 1ns/1ps
module sync_hunt_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       rx_bit = 1'b0;
  logic       rx_valid = 1'b0;
  logic [1:0] mode = 2'b00;
  logic [7:0] sync_a = 8'h00;
  logic [7:0] sync_b = 8'h00;
  logic       hunt_restart = 1'b0;
  logic       in_sync;
  logic       char_valid;
  logic [7:0] char_data;

  int checks = 0;
  int errors = 0;
  int n_chars = 0;
  logic [7:0] last_char = 8'h00;

  always #4 clk = ~clk; // 125 MHz

  sync_hunt u_sync_hunt (
    .clk(clk), .rst_n(rst_n), .rx_bit(rx_bit), .rx_valid(rx_valid),
    .mode(mode), .sync_a(sync_a), .sync_b(sync_b),
    .hunt_restart(hunt_restart), .in_sync(in_sync),
    .char_valid(char_valid), .char_data(char_data)
  );

  // Character monitor, sampled just after each rising edge.
  always @(posedge clk) begin
    #1;
    if (char_valid) begin
      n_chars++;
      last_char = char_data;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  task automatic send_bit(input logic b, input int gap = 0);
    rx_bit = b; rx_valid = 1'b1;
    @(negedge clk);
    rx_valid = 1'b0;
    for (int g = 0; g < gap; g++) begin
      rx_bit = ~rx_bit;
      @(negedge clk);
    end
  endtask

  task automatic send_byte(input logic [7:0] v, input int gap = 0);
    for (int i = 0; i < 8; i++) send_bit(v[i], gap);
  endtask

  task automatic restart();
    hunt_restart = 1'b1;
    @(negedge clk);
    hunt_restart = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1 in_sync after reset", in_sync, 0);
    chk("R1 char_valid after reset", char_valid, 0);
  endtask

  task automatic t_single();
    int base;
    mode = 2'b00; sync_b = 8'hA7; sync_a = 8'hFF;
    restart();
    send_bit(1); send_bit(0); send_bit(1);
    for (int i = 0; i < 7; i++) send_bit(sync_b[i]);
    chk("R2 no sync before last pattern bit", in_sync, 0);
    send_bit(sync_b[7]);
    chk("R2 sync at unaligned offset", in_sync, 1);
    base = n_chars;
    send_byte(8'h3C);
    chk("R7 first char count", n_chars - base, 1);
    chk("R7 first char data", last_char, 8'h3C);
    send_byte(8'hE1);
    chk("R7 second char data", last_char, 8'hE1);
    send_byte(8'hA7);
    chk("R9 sync byte delivered as data", last_char, 8'hA7);
    chk("R9 still in sync", in_sync, 1);
    chk("R7 char count after three bytes", n_chars - base, 3);
  endtask

  task automatic t_dual();
    mode = 2'b01; sync_a = 8'h5A; sync_b = 8'hC3;
    restart();
    send_byte(8'h00);
    send_byte(8'hC3);
    chk("R3 lone second sync char gives no sync", in_sync, 0);
    send_byte(8'h5A);
    for (int i = 0; i < 7; i++) send_bit(sync_b[i]);
    chk("R3 no sync one bit early", in_sync, 0);
    send_bit(sync_b[7]);
    chk("R3 dual sync acquired", in_sync, 1);
    send_byte(8'h99);
    chk("R7 dual mode char data", last_char, 8'h99);
  endtask

  task automatic t_fill();
    mode = 2'b01; sync_a = 8'h00; sync_b = 8'h00;
    restart();
    for (int i = 0; i < 15; i++) send_bit(0);
    chk("R5 dual no sync at 15 bits", in_sync, 0);
    send_bit(0);
    chk("R5 dual sync at 16 bits", in_sync, 1);
    mode = 2'b00;
    restart();
    for (int i = 0; i < 7; i++) send_bit(0);
    chk("R5 single no sync at 7 bits", in_sync, 0);
    send_bit(0);
    chk("R5 single sync at 8 bits", in_sync, 1);
  endtask

  task automatic t_flag();
    mode = 2'b10; sync_a = 8'h12; sync_b = 8'h7E;
    restart();
    send_bit(1);
    send_byte(8'h7E);
    chk("R4 flag sync with unrelated sync_a", in_sync, 1);
    mode = 2'b11; sync_a = 8'h7E; sync_b = 8'h55;
    restart();
    send_byte(8'h7E);
    chk("R4 sync_a ignored in flag mode", in_sync, 0);
    send_byte(8'h55);
    chk("R4 flag sync on 2'b11", in_sync, 1);
  endtask

  task automatic t_gaps();
    int base;
    mode = 2'b00; sync_b = 8'h2D;
    restart();
    send_byte(8'h2D, 2);
    chk("R6 sync with idle gaps", in_sync, 1);
    base = n_chars;
    send_byte(8'hB4, 3);
    chk("R6 gap char count", n_chars - base, 1);
    chk("R6 gap char data", last_char, 8'hB4);
  endtask

  task automatic t_restart();
    int base;
    mode = 2'b00; sync_b = 8'hC5;
    restart();
    send_byte(8'hC5);
    chk("R8 setup sync", in_sync, 1);
    send_bit(1); send_bit(1); send_bit(1); send_bit(1);
    restart();
    chk("R8 restart clears sync", in_sync, 0);
    for (int i = 0; i < 7; i++) send_bit(sync_b[i]);
    rx_bit = sync_b[7]; rx_valid = 1'b1; hunt_restart = 1'b1;
    @(negedge clk);
    rx_valid = 1'b0; hunt_restart = 1'b0;
    chk("R8 restart beats completing bit", in_sync, 0);
    send_byte(8'hC5);
    chk("R8 resync after restart", in_sync, 1);
    base = n_chars;
    send_byte(8'h0F);
    chk("R8 no stale bits in char", last_char, 8'h0F);
    chk("R8 one char after resync", n_chars - base, 1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog actual=hung expected=done");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_single();
    t_dual();
    t_fill();
    t_flag();
    t_gaps();
    t_restart();
    repeat (3) @(negedge clk);
    finish_run();
  end
endmodule